// File: doc/BRIEF.md
# Security-Keyed Memory Region Guard

This block sits in front of one memory controller port. It checks every access against a small set of programmable address windows. Each window has an inclusive lower and upper address bound, an enable flag, and four rights. Those rights are read and write for secure requesters, and read and write for non-secure requesters. For each access the guard finds the window that covers the address. It then looks at the request's security attribute and direction and either forwards the access to the memory side or answers it with an error. The processor only sees such errors as delayed aborts, so the guard must block a forbidden access completely: a forbidden write never reaches the memory side.

The windows are programmed through a small register port that only secure requesters may write. The rights can make a window secure-only, non-secure-only or shared. They can also make a one-way exchange window, where one security state may only write and the other may only read. When windows overlap, the one with the higher index decides. An address that no enabled window covers is treated as secure-only. The first rejected access is recorded in a sticky fault record, and an interrupt stays raised until a secure requester clears it.

Top module: `region_guard`

## Requirements
- R1: An allowed access (reqValid high in one cycle) appears on the memory side exactly one clock later, with memValid high and the same address, direction, security attribute and write data; errValid stays low.
- R2: A rejected access raises errValid for exactly one cycle, one clock after the request, and memValid stays low in that cycle, so a rejected write never reaches the memory side.
- R3: NUM_REGIONS windows (default 4, at least 3) are provided. A window covers an address when its enable bit is set and base <= address <= limit, with both bounds inclusive. A disabled window covers nothing.
- R4: The covering window's rights decide the outcome. Config field 2 holds the rights: bit0 is enable, bit1 secure read, bit2 secure write, bit3 non-secure read, bit4 non-secure write. A secure-only, non-secure-only or shared window therefore accepts exactly the matching requesters.
- R5: A window with secure write and non-secure read only (or the reverse) accepts exactly those two kinds of access and rejects the other two.
- R6: When several enabled windows cover an address, the window with the highest index decides.
- R7: An address that no enabled window covers accepts secure reads and writes and rejects all non-secure accesses.
- R8: Config writes (cfgValid high) take effect on the next clock only when cfgNonSec is low. Non-secure config writes change nothing. cfgField selects the target: 0 is base, 1 is limit, 2 is rights, 3 is fault clear. cfgRegion selects the window.
- R9: The first rejected access while no fault is held captures its address, security attribute and direction into faultAddr/faultNonSec/faultWrite. Later rejections leave the record unchanged until it is cleared.
- R10: faultIrq rises together with the capture and stays high until a secure write to field 3. A non-secure clear is ignored. A rejection in the same cycle as a clear is captured as a new fault.
- R11: After reset, all windows are disabled with zero bounds, and memValid, errValid and faultIrq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access request present |
| reqAddr | input | ADDR_W | Access address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqNonSec | input | 1 | 1 = non-secure requester |
| reqWdata | input | DATA_W | Write data |
| cfgValid | input | 1 | Config write strobe |
| cfgNonSec | input | 1 | Security attribute of the config write |
| cfgRegion | input | IDX_W | Target window index |
| cfgField | input | 2 | 0 base, 1 limit, 2 rights, 3 fault clear |
| cfgData | input | ADDR_W | Config write data |
| memValid | output | 1 | Forwarded access to the memory side |
| memAddr | output | ADDR_W | Forwarded address |
| memWrite | output | 1 | Forwarded direction |
| memNonSec | output | 1 | Forwarded security attribute |
| memWdata | output | DATA_W | Forwarded write data |
| errValid | output | 1 | Error response for a rejected access |
| faultIrq | output | 1 | Sticky fault interrupt |
| faultAddr | output | ADDR_W | Address of the captured rejection |
| faultNonSec | output | 1 | Security attribute of the captured rejection |
| faultWrite | output | 1 | Direction of the captured rejection |

## Verification
Some properties are checked on every cycle by assertions. The memory side and the error response are never active together. Every request produces exactly one of the two a cycle later. The interrupt rises only together with an error response. The fault record holds steady while the interrupt is set and no secure clear arrives. Other behaviour can only be shown by the bench's scenarios, because it depends on programmed window contents. These are the inclusive bound edges, overlap priority, the default secure-only treatment, one-way exchange windows, and the refusal of non-secure configuration and clear writes.

// File: rtl/rg_pkg.sv
package rg_pkg;
  localparam logic [1:0] FIELD_BASE  = 2'd0;
  localparam logic [1:0] FIELD_LIMIT = 2'd1;
  localparam logic [1:0] FIELD_ATTR  = 2'd2;
  localparam logic [1:0] FIELD_CLEAR = 2'd3;

  typedef struct packed {
    logic en;
    logic sRd;
    logic sWr;
    logic nsRd;
    logic nsWr;
  } regionAttr_t;

  typedef struct packed {
    logic wrBase;
    logic wrLimit;
    logic wrAttr;
    logic clrFault;
    logic capFault;
  } ctrlStrobe_t;
endpackage

// File: rtl/rg_ctrl.sv
module rg_ctrl
  import rg_pkg::*;
(
  input  logic        cfgValid,
  input  logic        cfgNonSec,
  input  logic [1:0]  cfgField,
  input  logic        accessReject,
  input  logic        faultActive,
  output ctrlStrobe_t strobe
);
  logic secureCfg;

  always_comb begin
    secureCfg       = cfgValid && !cfgNonSec;
    strobe.wrBase   = secureCfg && (cfgField == FIELD_BASE);
    strobe.wrLimit  = secureCfg && (cfgField == FIELD_LIMIT);
    strobe.wrAttr   = secureCfg && (cfgField == FIELD_ATTR);
    strobe.clrFault = secureCfg && (cfgField == FIELD_CLEAR);
    // a fault is held until cleared; a clear frees the record in the same cycle
    strobe.capFault = accessReject && (!faultActive || strobe.clrFault);
  end
endmodule

// File: rtl/rg_datapath.sv
module rg_datapath
  import rg_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [IDX_W-1:0]  cfgRegion,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqNonSec,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              accessReject,
  output logic              faultActive,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrite,
  output logic              memNonSec,
  output logic [DATA_W-1:0] memWdata,
  output logic              errValid,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              faultNonSec,
  output logic              faultWrite
);
  logic [ADDR_W-1:0] baseQ  [NUM_REGIONS];
  logic [ADDR_W-1:0] limitQ [NUM_REGIONS];
  regionAttr_t       attrQ  [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] hit;
  regionAttr_t       selAttr;
  logic              allow;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
    logic selected;
    assign selected = (cfgRegion == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ[g]  <= '0;
        limitQ[g] <= '0;
        attrQ[g]  <= '0;
      end else begin
        if (strobe.wrBase && selected)  baseQ[g]  <= cfgData;
        if (strobe.wrLimit && selected) limitQ[g] <= cfgData;
        if (strobe.wrAttr && selected) begin
          attrQ[g].en   <= cfgData[0];
          attrQ[g].sRd  <= cfgData[1];
          attrQ[g].sWr  <= cfgData[2];
          attrQ[g].nsRd <= cfgData[3];
          attrQ[g].nsWr <= cfgData[4];
        end
      end
    end

    assign hit[g] = attrQ[g].en && (reqAddr >= baseQ[g]) && (reqAddr <= limitQ[g]);
  end

  // ascending scan: the highest matching index is written last and wins
  always_comb begin
    selAttr = '{en: 1'b0, sRd: 1'b1, sWr: 1'b1, nsRd: 1'b0, nsWr: 1'b0};
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hit[i]) selAttr = attrQ[i];
    end
    if (reqNonSec) allow = reqWrite ? selAttr.nsWr : selAttr.nsRd;
    else           allow = reqWrite ? selAttr.sWr  : selAttr.sRd;
    accessReject = reqValid && !allow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memValid  <= 1'b0;
      errValid  <= 1'b0;
      memAddr   <= '0;
      memWrite  <= 1'b0;
      memNonSec <= 1'b0;
      memWdata  <= '0;
    end else begin
      memValid  <= reqValid && allow;
      errValid  <= accessReject;
      memAddr   <= reqAddr;
      memWrite  <= reqWrite;
      memNonSec <= reqNonSec;
      memWdata  <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultActive <= 1'b0;
      faultAddr   <= '0;
      faultNonSec <= 1'b0;
      faultWrite  <= 1'b0;
    end else if (strobe.capFault) begin
      faultActive <= 1'b1;
      faultAddr   <= reqAddr;
      faultNonSec <= reqNonSec;
      faultWrite  <= reqWrite;
    end else if (strobe.clrFault) begin
      faultActive <= 1'b0;
    end
  end
endmodule

// File: rtl/region_guard.sv
module region_guard
  import rg_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqNonSec,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              cfgValid,
  input  logic              cfgNonSec,
  input  logic [IDX_W-1:0]  cfgRegion,
  input  logic [1:0]        cfgField,
  input  logic [ADDR_W-1:0] cfgData,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrite,
  output logic              memNonSec,
  output logic [DATA_W-1:0] memWdata,
  output logic              errValid,
  output logic              faultIrq,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              faultNonSec,
  output logic              faultWrite
);
  ctrlStrobe_t strobe;
  logic        accessReject;
  logic        faultActive;

  rg_ctrl u_ctrl (
    .cfgValid     (cfgValid),
    .cfgNonSec    (cfgNonSec),
    .cfgField     (cfgField),
    .accessReject (accessReject),
    .faultActive  (faultActive),
    .strobe       (strobe)
  );

  rg_datapath #(
    .NUM_REGIONS (NUM_REGIONS),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cfgRegion    (cfgRegion),
    .cfgData      (cfgData),
    .reqValid     (reqValid),
    .reqAddr      (reqAddr),
    .reqWrite     (reqWrite),
    .reqNonSec    (reqNonSec),
    .reqWdata     (reqWdata),
    .accessReject (accessReject),
    .faultActive  (faultActive),
    .memValid     (memValid),
    .memAddr      (memAddr),
    .memWrite     (memWrite),
    .memNonSec    (memNonSec),
    .memWdata     (memWdata),
    .errValid     (errValid),
    .faultAddr    (faultAddr),
    .faultNonSec  (faultNonSec),
    .faultWrite   (faultWrite)
  );

  assign faultIrq = faultActive;
endmodule

// File: rtl/rg_checker.sv
module rg_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              cfgValid,
  input logic              cfgNonSec,
  input logic [1:0]        cfgField,
  input logic              memValid,
  input logic              errValid,
  input logic              faultIrq,
  input logic [ADDR_W-1:0] faultAddr,
  input logic [IDX_W-1:0]  cfgRegion
);
  logic secureClear;
  assign secureClear = cfgValid && !cfgNonSec && (cfgField == 2'd3);

  // R2
  exclusive_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memValid, errValid}));

  // R1
  one_cycle_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (memValid || errValid));

  // R1
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!memValid && !errValid));

  // R10
  irq_with_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultIrq) |-> errValid);

  // R9
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultIrq && !secureClear) |=> (faultIrq && $stable(faultAddr)));

  logic unusedRegion;
  assign unusedRegion = ^cfgRegion;
endmodule

bind region_guard rg_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rg_checker (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .cfgValid  (cfgValid),
  .cfgNonSec (cfgNonSec),
  .cfgField  (cfgField),
  .memValid  (memValid),
  .errValid  (errValid),
  .faultIrq  (faultIrq),
  .faultAddr (faultAddr),
  .cfgRegion (cfgRegion)
);

// File: tb/test_region_guard.sv
module test_region_guard;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqWrite = 1'b0;
  logic              reqNonSec = 1'b0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              cfgValid = 1'b0;
  logic              cfgNonSec = 1'b0;
  logic [1:0]        cfgRegion = '0;
  logic [1:0]        cfgField = '0;
  logic [ADDR_W-1:0] cfgData = '0;
  logic              memValid, memWrite, memNonSec, errValid, faultIrq, faultNonSec, faultWrite;
  logic [ADDR_W-1:0] memAddr, faultAddr;
  logic [DATA_W-1:0] memWdata;

  int vecCount = 0;
  int missCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_guard i_region_guard (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqNonSec(reqNonSec), .reqWdata(reqWdata),
    .cfgValid(cfgValid), .cfgNonSec(cfgNonSec), .cfgRegion(cfgRegion),
    .cfgField(cfgField), .cfgData(cfgData),
    .memValid(memValid), .memAddr(memAddr), .memWrite(memWrite),
    .memNonSec(memNonSec), .memWdata(memWdata), .errValid(errValid),
    .faultIrq(faultIrq), .faultAddr(faultAddr),
    .faultNonSec(faultNonSec), .faultWrite(faultWrite)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  endtask

  task automatic cfgWrite(input bit ns, input int idx, input int field, input logic [ADDR_W-1:0] data);
    @(negedge clk);
    cfgValid = 1'b1; cfgNonSec = ns; cfgRegion = 2'(idx); cfgField = 2'(field); cfgData = data;
    @(negedge clk);
    cfgValid = 1'b0;
  endtask

  task automatic setRegion(input int idx, input logic [ADDR_W-1:0] lo, input logic [ADDR_W-1:0] hi, input logic [4:0] attr);
    cfgWrite(1'b0, idx, 0, lo);
    cfgWrite(1'b0, idx, 1, hi);
    cfgWrite(1'b0, idx, 2, {27'd0, attr});
  endtask

  // drive one access, sample one clock later away from the edge
  task automatic access(input logic [ADDR_W-1:0] addr, input bit wr, input bit ns, input bit expOk, input string tag);
    logic [DATA_W-1:0] d;
    d = addr ^ 32'hA5A5_0000;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqWrite = wr; reqNonSec = ns; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    if (expOk) begin
      check(memValid && !errValid && memAddr == addr && memWrite == wr && memNonSec == ns && memWdata == d,
            tag, {memValid, errValid, memAddr}, {1'b1, 1'b0, addr});
    end else begin
      check(!memValid && errValid, tag, {memValid, errValid}, 2'b01);
    end
  endtask

  task automatic checkFault(input bit irq, input logic [ADDR_W-1:0] a, input bit ns, input bit wr, input string tag);
    check(faultIrq == irq && faultAddr == a && faultNonSec == ns && faultWrite == wr, tag,
          {faultIrq, faultNonSec, faultWrite, faultAddr}, {irq, ns, wr, a});
  endtask

  task automatic testReset();
    // R11
    check(!memValid && !errValid && !faultIrq, "R11 reset outputs", {memValid, errValid, faultIrq}, 0);
  endtask

  task automatic testUnmapped();
    access(32'h5000, 1'b0, 1'b0, 1'b1, "R7 secure read unmapped");
    access(32'h5004, 1'b1, 1'b0, 1'b1, "R7 secure write unmapped");
    access(32'h5000, 1'b0, 1'b1, 1'b0, "R7 non-secure read unmapped");
    checkFault(1'b1, 32'h5000, 1'b1, 1'b0, "R9 first fault captured");
  endtask

  task automatic testBounds();
    setRegion(0, 32'h1000, 32'h1FFF, 5'b11001);   // en, nsRd, nsWr
    access(32'h1800, 1'b1, 1'b1, 1'b1, "R1 non-secure write forwarded");
    access(32'h1800, 1'b0, 1'b0, 1'b0, "R4 secure read of non-secure window");
    access(32'h1000, 1'b0, 1'b1, 1'b1, "R3 base inclusive");
    access(32'h1FFF, 1'b0, 1'b1, 1'b1, "R3 limit inclusive");
    access(32'h2000, 1'b1, 1'b1, 1'b0, "R2 write past limit rejected");
    checkFault(1'b1, 32'h5000, 1'b1, 1'b0, "R9 record not overwritten");
  endtask

  task automatic testOneWay();
    setRegion(1, 32'h3000, 32'h3FFF, 5'b01101);   // en, sWr, nsRd
    access(32'h3100, 1'b1, 1'b0, 1'b1, "R5 secure write allowed");
    access(32'h3100, 1'b0, 1'b1, 1'b1, "R5 non-secure read allowed");
    access(32'h3100, 1'b1, 1'b1, 1'b0, "R5 non-secure write rejected");
    access(32'h3100, 1'b0, 1'b0, 1'b0, "R5 secure read rejected");
  endtask

  task automatic testOverlap();
    setRegion(2, 32'h1800, 32'h18FF, 5'b00111);   // en, sRd, sWr
    access(32'h1880, 1'b0, 1'b1, 1'b0, "R6 higher window denies non-secure");
    access(32'h1880, 1'b0, 1'b0, 1'b1, "R6 higher window allows secure");
    access(32'h1900, 1'b0, 1'b1, 1'b1, "R6 lower window outside overlap");
    setRegion(3, 32'h0, 32'hFF, 5'b11111);
    access(32'h0040, 1'b1, 1'b1, 1'b1, "R4 shared non-secure write");
    access(32'h0040, 1'b0, 1'b0, 1'b1, "R4 shared secure read");
  endtask

  task automatic testCfgSecurity();
    cfgWrite(1'b1, 3, 2, 32'h0);                  // non-secure attempt to disable
    access(32'h0040, 1'b0, 1'b1, 1'b1, "R8 non-secure config write ignored");
    cfgWrite(1'b0, 0, 2, 32'h0);                  // secure disable of window 0
    access(32'h1C00, 1'b0, 1'b1, 1'b0, "R3 disabled window covers nothing");
  endtask

  task automatic testFaultClear();
    cfgWrite(1'b1, 0, 3, 32'h0);
    checkFault(1'b1, 32'h5000, 1'b1, 1'b0, "R10 non-secure clear ignored");
    cfgWrite(1'b0, 0, 3, 32'h0);
    check(!faultIrq, "R10 secure clear", faultIrq, 0);
    access(32'h3200, 1'b1, 1'b1, 1'b0, "R2 rejected write");
    checkFault(1'b1, 32'h3200, 1'b1, 1'b1, "R9 new fault after clear");
    // clear and rejection in the same cycle: new fault is captured
    @(negedge clk);
    cfgValid = 1'b1; cfgNonSec = 1'b0; cfgField = 2'd3;
    reqValid = 1'b1; reqAddr = 32'h3300; reqWrite = 1'b0; reqNonSec = 1'b0;
    @(negedge clk);
    cfgValid = 1'b0; reqValid = 1'b0;
    checkFault(1'b1, 32'h3300, 1'b0, 1'b0, "R10 clear with simultaneous rejection");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testUnmapped();
    testBounds();
    testOneWay();
    testOverlap();
    testCfgSecurity();
    testFaultClear();
    repeat (2) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    vecCount++;
    missCount++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end
endmodule